// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial slave that lets a host set up a converter's operating modes over a four-wire serial port. The port has an active-low chip select, a serial clock and a data-in line. It also has a data-out line that can only pull low. Every transaction is a 16-bit command frame made of three parts:

- a read/write flag;
- a 7-bit register address;
- an 8-bit data byte.

A write frame stores the byte in the addressed mode register. A read frame shifts the addressed register out, MSB first, by pulling the data-out line low for each zero bit.

The serial inputs are oversampled by the system clock through synchronizer stages, and all state lives in the system clock domain. Address 00h is a write-only command register: writing bit 7 high clears every mode register and raises the sleep output for a short, fixed number of cycles. Address 01h is decoded into six registered control outputs:

- clock duty-cycle stabilizer disable;
- output randomizer enable;
- two's-complement select;
- global sleep;
- nap for channel 1;
- nap for channel 2.

Addresses from 02h up to NUM_REGS-1 are plain storage bytes.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame is sampled on rising serial-clock edges while chip select is low. Bit 1 is the read/write flag (0 = write), bits 2 to 8 are the address MSB first, and bits 9 to 16 are the data MSB first. On the 16th edge of a write frame, the data byte is stored in the addressed register.
- R2: Rising serial-clock edges after the 16th in one frame have no effect on any register.
- R3: A frame that ends, with chip select returning high, before 16 rising edges stores nothing. The bit counter is cleared while chip select is high, so the next frame starts from bit 1.
- R4: In a read frame, the addressed register's value is presented on data-out MSB first. Each bit changes after a falling serial-clock edge, from the falling edge after edge 8 through the falling edge after edge 15, so the host samples it at edges 9 to 16. A read leaves the register unchanged and discards its data bits.
- R5: Data-out is open-drain: sdo_pull_low = 1 means the line is pulled low, and 0 means it is released. It stays released while chip select is high and throughout write frames.
- R6: A write to address 00h with data bit 7 = 1 clears every mode register to 00h. A write to 00h with bit 7 = 0 changes nothing, and a read of 00h returns 00h.
- R7: A software reset holds the sleep output high for exactly RST_SLEEP_CYC system-clock cycles (default 4) when the sleep bit was clear beforehand.
- R8: For register 01h, bit 7 drives dcs_off, bit 6 drives rand_en and bit 5 drives twos_comp (1 = two's complement, 0 = offset binary). Bits 2 and 1 drive nothing.
- R9: Register 01h bit 4 = 1 drives sleep high and forces both nap outputs low. With bit 4 clear, bit 0 drives nap_ch1 and bit 3 drives nap_ch2, independently of each other.
- R10: Addresses 02h to NUM_REGS-1 are read/write storage bytes. Addresses at or above NUM_REGS read as 00h, and writes to them change nothing.
- R11: After a synchronous reset, all registers are 00h, all control outputs are 0 and data-out is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial port |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Active-low chip select; frame boundary |
| spi_sck | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| sdo_pull_low | output | 1 | 1 = pull data-out line low, 0 = release |
| dcs_off | output | 1 | Duty-cycle stabilizer disable |
| rand_en | output | 1 | Output randomizer enable |
| twos_comp | output | 1 | Two's-complement format select |
| sleep | output | 1 | Both channels disabled (sleep bit or reset pulse) |
| nap_ch1 | output | 1 | Channel 1 nap |
| nap_ch2 | output | 1 | Channel 2 nap |

## Verification
A bit counter that is off by one misaligns the address and data fields. This shows at once on the control outputs of the next write frame, and on the byte read back in the following frame. A read flag latched at the wrong time shows as data-out pulling low during a write frame or while chip select is high. A storage register written by a read, or by a truncated or over-long frame, shows as a changed value on the next read-back. A faulty reset pulse counter shows as the sleep output being high for a cycle count other than RST_SLEEP_CYC, measured within a few cycles of the reset frame's 16th edge.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int HDR_BITS   = 1 + ADDR_W;

  // command register (address 0)
  localparam int SWRST_BIT  = 7;
  // mode register (address 1) field positions
  localparam int F_DCSOFF   = 7;
  localparam int F_RAND     = 6;
  localparam int F_TWOS     = 5;
  localparam int F_SLEEP    = 4;
  localparam int F_NAP2     = 3;
  localparam int F_NAP1     = 0;

  typedef struct packed {
    logic dcs_off;
    logic rand_en;
    logic twos_comp;
    logic sleep;
    logic nap_ch1;
    logic nap_ch2;
  } ctrl_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csn_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic active_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdi_o
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b100;  // csn high, sck low, sdi low

  logic [NSIG-1:0] pipe_q [SYNC_STAGES];
  logic            sck_d_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe_q[g] <= IDLE;
        else if (g == 0) pipe_q[g] <= {csn_i, sck_i, sdi_i};
        else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_d_q <= 1'b0;
    else     sck_d_q <= pipe_q[SYNC_STAGES-1][1];
  end

  assign active_o   = ~pipe_q[SYNC_STAGES-1][2];
  assign sck_rise_o =  pipe_q[SYNC_STAGES-1][1] & ~sck_d_q;
  assign sck_fall_o = ~pipe_q[SYNC_STAGES-1][1] &  sck_d_q;
  assign sdi_o      =  pipe_q[SYNC_STAGES-1][0];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_pull_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [CW-1:0]         bit_cnt_q;
  logic [FRAME_BITS-2:0] shreg_q;
  logic [DATA_W-1:0]     tx_q;
  logic                  reading_q;
  logic                  sdo_q;

  // address as complete on the edge that brings in the last header bit
  assign rd_addr_o = {shreg_q[ADDR_W-2:0], sdi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      reading_q <= 1'b0;
      sdo_q     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (!active_i) begin
      bit_cnt_q <= '0;
      reading_q <= 1'b0;
      sdo_q     <= 1'b0;
      wr_en_o   <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (sck_rise_i && bit_cnt_q < CW'(FRAME_BITS)) begin
        shreg_q   <= {shreg_q[FRAME_BITS-3:0], sdi_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == CW'(HDR_BITS - 1)) begin
          reading_q <= shreg_q[ADDR_W-1];
          tx_q      <= rd_data_i;
        end
        if (bit_cnt_q == CW'(FRAME_BITS - 1) && !shreg_q[FRAME_BITS-2]) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= shreg_q[DATA_W-1 +: ADDR_W];
          wr_data_o <= {shreg_q[DATA_W-2:0], sdi_i};
        end
      end
      if (sck_fall_i) begin
        if (reading_q && bit_cnt_q >= CW'(HDR_BITS) && bit_cnt_q < CW'(FRAME_BITS)) begin
          sdo_q <= ~tx_q[DATA_W-1];
          tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_pull_o = sdo_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt_q <= CW'(FRAME_BITS));
  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> bit_cnt_q == '0);
  p_wr_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(sck_rise_i));
  p_no_wr_on_read_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> !reading_q);
  p_sdo_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> !sdo_pull_o);
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS      = 4,
  parameter int RST_SLEEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] mode_o,
  output logic              pulse_o
);
  localparam int PW = $clog2(RST_SLEEP_CYC + 1);

  logic [DATA_W-1:0] regs_q [NUM_REGS-1:1];
  logic [PW-1:0]     pulse_cnt_q;
  logic              swrst;

  assign swrst = wr_en_i && wr_addr_i == '0 && wr_data_i[SWRST_BIT];

  always_ff @(posedge clk) begin
    if (rst || swrst) begin
      for (int i = 1; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 1; i < NUM_REGS; i++)
        if (wr_addr_i == ADDR_W'(i)) regs_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    pulse_cnt_q <= '0;
    else if (swrst)             pulse_cnt_q <= PW'(RST_SLEEP_CYC);
    else if (pulse_cnt_q != '0) pulse_cnt_q <= pulse_cnt_q - 1'b1;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 1; i < NUM_REGS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
  end

  assign mode_o  = regs_q[1];
  assign pulse_o = pulse_cnt_q != '0;

  p_swrst_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == '0 && wr_data_i[SWRST_BIT]) |=> mode_o == '0);
  p_swrst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == '0 && wr_data_i[SWRST_BIT]) |=> pulse_o);
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mode_i,
  input  logic              pulse_i,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
    end else begin
      ctrl_o.dcs_off   <= mode_i[F_DCSOFF];
      ctrl_o.rand_en   <= mode_i[F_RAND];
      ctrl_o.twos_comp <= mode_i[F_TWOS];
      ctrl_o.sleep     <= mode_i[F_SLEEP] | pulse_i;
      ctrl_o.nap_ch1   <= ~mode_i[F_SLEEP] & mode_i[F_NAP1];
      ctrl_o.nap_ch2   <= ~mode_i[F_SLEEP] & mode_i[F_NAP2];
    end
  end

  p_sleep_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> ctrl_o.sleep);
  p_sleep_excl_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_o.sleep |-> !ctrl_o.nap_ch1 && !ctrl_o.nap_ch2);
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS      = 4,
  parameter int RST_SLEEP_CYC = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_sdi,
  output logic sdo_pull_low,
  output logic dcs_off,
  output logic rand_en,
  output logic twos_comp,
  output logic sleep,
  output logic nap_ch1,
  output logic nap_ch2
);
  logic              active, sck_rise, sck_fall, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data, mode;
  logic              wr_en, pulse;
  ctrl_t             ctrl;

  spi_cfg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .csn_i(spi_csn), .sck_i(spi_sck), .sdi_i(spi_sdi),
    .active_o(active), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sdi_o(sdi_s)
  );

  spi_cfg_frame u_frame (
    .clk(clk), .rst(rst), .active_i(active), .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall), .sdi_i(sdi_s), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .sdo_pull_o(sdo_pull_low)
  );

  spi_cfg_regs #(.NUM_REGS(NUM_REGS), .RST_SLEEP_CYC(RST_SLEEP_CYC)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mode_o(mode), .pulse_o(pulse)
  );

  spi_cfg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode), .pulse_i(pulse), .ctrl_o(ctrl)
  );

  assign dcs_off   = ctrl.dcs_off;
  assign rand_en   = ctrl.rand_en;
  assign twos_comp = ctrl.twos_comp;
  assign sleep     = ctrl.sleep;
  assign nap_ch1   = ctrl.nap_ch1;
  assign nap_ch2   = ctrl.nap_ch2;
endmodule

// File: tb/spi_cfg_slave_tb.sv
module spi_cfg_slave_tb;
  localparam int HALF = 8;  // system clocks per serial clock half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
  logic sdo_pull_low, dcs_off, rand_en, twos_comp, sleep, nap_ch1, nap_ch2;

  int n_checks = 0, n_fail = 0;
  int pull_seen = 0, sleep_cycles = 0;
  logic quiet = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  spi_cfg_slave u_dut (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
    .sdo_pull_low(sdo_pull_low), .dcs_off(dcs_off), .rand_en(rand_en),
    .twos_comp(twos_comp), .sleep(sleep), .nap_ch1(nap_ch1), .nap_ch2(nap_ch2)
  );

  always @(negedge clk) begin
    if ((quiet || spi_csn) && sdo_pull_low) pull_seen++;
    if (sleep) sleep_cycles++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits < 16 truncates, nbits > 16 appends ones
  task automatic xfer(input logic rw, input logic [6:0] addr, input logic [7:0] data,
                      input int nbits, output logic [7:0] rdata);
    logic [15:0] frame;
    frame = {rw, addr, data};
    rdata = 8'h00;
    quiet = !rw;
    wait_clk(1);
    spi_csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 16) ? frame[15-i] : 1'b1;
      wait_clk(HALF);
      if (i >= 8 && i < 16) rdata[15-i] = sdo_pull_low ? 1'b0 : 1'b1;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_csn = 1'b1;
    wait_clk(2 * HALF);
    quiet = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] unused;
    xfer(1'b0, a, d, 16, unused);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    xfer(1'b1, a, 8'h00, 16, d);
  endtask

  task automatic check_ctrl(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {dcs_off, rand_en, twos_comp, sleep, nap_ch2, nap_ch1};
    check(act == exp, req, act, exp);
  endtask

  task automatic t_reset_state;
    check_ctrl("R11 controls after reset", 6'b0);
    check(sdo_pull_low == 1'b0, "R11 data-out released", sdo_pull_low, 0);
  endtask

  task automatic t_write_decode;
    logic [7:0] d;
    wr(7'h01, 8'hE0);
    check_ctrl("R8 dcs/rand/twos from 01h=E0", 6'b111000);
    rd(7'h01, d);
    check(d == 8'hE0, "R1 R4 read back 01h", d, 8'hE0);
    wr(7'h01, 8'h20);
    check_ctrl("R8 twos only", 6'b001000);
    wr(7'h01, 8'h06);
    check_ctrl("R8 bits 2,1 drive nothing", 6'b000000);
  endtask

  task automatic t_nap_sleep;
    wr(7'h01, 8'h01); check_ctrl("R9 nap ch1", 6'b000001);
    wr(7'h01, 8'h08); check_ctrl("R9 nap ch2", 6'b000010);
    wr(7'h01, 8'h09); check_ctrl("R9 both naps", 6'b000011);
    wr(7'h01, 8'h19); check_ctrl("R9 sleep overrides naps", 6'b000100);
    wr(7'h01, 8'h00);
  endtask

  task automatic t_read_ignores;
    logic [7:0] d;
    wr(7'h02, 8'h5C);
    xfer(1'b1, 7'h02, 8'hFF, 16, d);
    check(d == 8'h5C, "R4 read data MSB first", d, 8'h5C);
    rd(7'h02, d);
    check(d == 8'h5C, "R4 read leaves register unchanged", d, 8'h5C);
  endtask

  task automatic t_storage;
    logic [7:0] d;
    wr(7'h02, 8'hA5);
    wr(7'h03, 8'h3C);
    rd(7'h02, d); check(d == 8'hA5, "R10 storage 02h", d, 8'hA5);
    rd(7'h03, d); check(d == 8'h3C, "R10 storage 03h", d, 8'h3C);
    wr(7'h05, 8'h77);
    rd(7'h05, d); check(d == 8'h00, "R10 unmapped reads 00h", d, 0);
    rd(7'h02, d); check(d == 8'hA5, "R10 unmapped write no effect", d, 8'hA5);
    rd(7'h03, d); check(d == 8'h3C, "R10 unmapped write no effect 03h", d, 8'h3C);
  endtask

  task automatic t_short_frame;
    logic [7:0] d;
    xfer(1'b0, 7'h02, 8'h11, 10, d);
    xfer(1'b0, 7'h02, 8'h22, 15, d);
    rd(7'h02, d);
    check(d == 8'hA5, "R3 truncated frames store nothing", d, 8'hA5);
    wr(7'h03, 8'h81);
    rd(7'h03, d);
    check(d == 8'h81, "R3 next frame aligned after short one", d, 8'h81);
  endtask

  task automatic t_long_frame;
    logic [7:0] d;
    xfer(1'b0, 7'h02, 8'h5A, 20, d);
    rd(7'h02, d);
    check(d == 8'h5A, "R2 edges after 16th ignored", d, 8'h5A);
  endtask

  task automatic t_swreset;
    logic [7:0] d;
    wr(7'h01, 8'hE9);
    check_ctrl("R8 R9 setup before reset", 6'b111011);
    wr(7'h00, 8'h7F);
    rd(7'h01, d);
    check(d == 8'hE9, "R6 bit7=0 at 00h no effect", d, 8'hE9);
    sleep_cycles = 0;
    wr(7'h00, 8'h80);
    check(sleep_cycles == 4, "R7 sleep pulse length", sleep_cycles, 4);
    check_ctrl("R6 controls cleared", 6'b000000);
    rd(7'h01, d); check(d == 8'h00, "R6 01h cleared", d, 0);
    rd(7'h02, d); check(d == 8'h00, "R6 02h cleared", d, 0);
    rd(7'h03, d); check(d == 8'h00, "R6 03h cleared", d, 0);
    rd(7'h00, d); check(d == 8'h00, "R6 00h reads 00h", d, 0);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset_state();
    t_write_decode();
    t_nap_sleep();
    t_read_ignores();
    t_storage();
    t_short_frame();
    t_long_frame();
    t_swreset();
    check(pull_seen == 0, "R5 no pull outside read data phase", pull_seen, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule